// File: doc/BRIEF.md
# Tiered Interrupt Controller with Diagnostic Override

This block gathers three tiers of event inputs (two clock-error lines, two system-error lines, and a group of general-purpose and frame-group event lines) into sticky status bits. Each status bit sets on a rising edge of its input and is cleared by software writing a one to it. Any status bit that is not masked drives a single active-low system error output.

A diagnostic register can substitute its own bits for one selected input in each tier group: both clock-error inputs, both system-error inputs, general-purpose input 0 and frame-group input 0. Software can then set and clear those status bits without driving the pins. The substitution is active only when the register's two-bit enable code selects it.

A second register programs a minimum idle time for the output. When the output releases because its request has gone away, it stays inactive for that many clock cycles before it can assert again. An interrupt that arrives during this window is held in status and asserts the output when the window ends. All registers sit behind a simple synchronous write port and a combinational read port.

Top module: `irq_diag_ctrl`

## Requirements
- R1: After reset, every status, mask, diagnostic and gap register reads 0 and sys_err_no is 1.
- R2: A status bit sets on a 0-to-1 transition of its effective input. An input held high does not set the bit again after it is cleared. Map: address 5 bits [1:0] are clock errors 1:0 and bits [3:2] are system errors 1:0; address 6 bit i is general-purpose input i; address 7 bit i is frame-group input i.
- R3: Writing a status address clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: sys_err_no goes to 0 on the second rising clock edge after an unmasked event input rises. A status bit whose mask bit is 1 (addresses 2, 3, 4, with the same bit layout as status) does not drive the output.
- R5: The override is active only when diagnostic register (address 0) bits [7:6] equal 2'b01. Codes 00, 10 and 11 leave every effective input equal to its pin.
- R6: While the override is active, diagnostic bits [5:4] drive clock errors [1:0] and bits [3:2] drive system errors [1:0]; the pins of those inputs are ignored.
- R7: While the override is active, diagnostic bit 1 drives general-purpose input 0 and bit 0 drives frame-group input 0; those two pins are ignored and all other general-purpose and frame-group pins pass through unchanged.
- R8: When sys_err_no returns to 1 with gap register (address 1) value G, it stays 1 for G cycles if G is 2 or more, and for 1 cycle otherwise, before a pending request can assert it again.
- R9: An interrupt that latches during the gap is not lost: sys_err_no asserts on the clock edge that ends the gap.
- R10: Registers read back what was written: address 0 diagnostic, address 1 gap.
- R11: sys_err_no returns to 1 one clock edge after no unmasked status bit remains, whether through clearing or through masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_err_i | input | 2 | Clock-error event inputs |
| sys_err_i | input | 2 | System-error event inputs |
| gp_evt_i | input | N_GP | General-purpose event inputs |
| fg_evt_i | input | N_FG | Frame-group event inputs |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 3 | Register write address |
| reg_wdata_i | input | DW | Register write data |
| reg_raddr_i | input | 3 | Register read address |
| reg_rdata_o | output | DW | Register read data (combinational) |
| sys_err_no | output | 1 | Active-low system error output |

## Verification
A wrong substitution in the override mux shows up at the status read port within two cycles of the diagnostic write, as a bit set that should not be or one missing from its tier. A corrupted edge detector either misses a latch or sets the bit again after a clear, and this is visible on the next status read. A fault in the gap sequencer changes the length of the high pulse on sys_err_no between two back-to-back interrupts. The bench measures that pulse cycle by cycle, so an error of one count shows within that gap.

// File: rtl/irq_diag_pkg.sv
`timescale 1ns/1ps
package irq_diag_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIAG     = 3'd0,
    REG_GAP      = 3'd1,
    REG_MASK_ERR = 3'd2,
    REG_MASK_GP  = 3'd3,
    REG_MASK_FG  = 3'd4,
    REG_STAT_ERR = 3'd5,
    REG_STAT_GP  = 3'd6,
    REG_STAT_FG  = 3'd7
  } reg_addr_e;

  localparam logic [1:0] DIAG_OVR_ON = 2'b01;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ACTIVE = 2'd1,
    SEQ_GAP    = 2'd2
  } seq_state_e;
endpackage

// File: rtl/irq_ovr_mux.sv
`timescale 1ns/1ps
module irq_ovr_mux
  import irq_diag_pkg::*;
#(
  parameter int unsigned N_GP = 8,
  parameter int unsigned N_FG = 8
) (
  input  logic [7:0]      diag_i,
  input  logic [1:0]      clk_err_i,
  input  logic [1:0]      sys_err_i,
  input  logic [N_GP-1:0] gp_evt_i,
  input  logic [N_FG-1:0] fg_evt_i,
  output logic [1:0]      clk_err_o,
  output logic [1:0]      sys_err_o,
  output logic [N_GP-1:0] gp_evt_o,
  output logic [N_FG-1:0] fg_evt_o
);
  logic ovr_on;
  assign ovr_on = (diag_i[7:6] == DIAG_OVR_ON);

  always_comb begin
    clk_err_o = clk_err_i;
    sys_err_o = sys_err_i;
    gp_evt_o  = gp_evt_i;
    fg_evt_o  = fg_evt_i;
    if (ovr_on) begin
      clk_err_o   = diag_i[5:4];
      sys_err_o   = diag_i[3:2];
      gp_evt_o[0] = diag_i[1];
      fg_evt_o[0] = diag_i[0];
    end
  end
endmodule

// File: rtl/irq_tier.sv
`timescale 1ns/1ps
module irq_tier #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] status_o,
  output logic         req_o
);
  logic [W-1:0] rise;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic prev_q;
    logic stat_q;
    assign rise[b] = evt_i[b] & ~prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b0;
        stat_q <= 1'b0;
      end else begin
        prev_q <= evt_i[b];
        stat_q <= rise[b] | (stat_q & ~clr_i[b]);  // set wins over clear
      end
    end
    assign status_o[b] = stat_q;
  end

  assign req_o = |(status_o & ~mask_i);

  // R2
  rise_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((status_o & $past(rise)) == $past(rise)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i != '0) |=> ((status_o & $past(clr_i & ~rise)) == '0));
endmodule

// File: rtl/irq_gap_seq.sv
`timescale 1ns/1ps
module irq_gap_seq
  import irq_diag_pkg::*;
#(
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             sys_err_no
);
  seq_state_e       state_q;
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (req_i) state_q <= SEQ_ACTIVE;
        SEQ_ACTIVE: begin
          if (!req_i) begin
            if (gap_i == '0) begin
              state_q <= SEQ_IDLE;
            end else begin
              state_q <= SEQ_GAP;
              cnt_q   <= gap_i;
            end
          end
        end
        SEQ_GAP: begin
          if (cnt_q <= GAP_W'(1)) state_q <= req_i ? SEQ_ACTIVE : SEQ_IDLE;
          else                    cnt_q   <= cnt_q - GAP_W'(1);
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign sys_err_no = (state_q != SEQ_ACTIVE);

  // R11
  no_req_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> sys_err_no);

  // R4
  idle_assert_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_err_no && req_i && state_q == SEQ_IDLE) |=> !sys_err_no);

  // R4
  assert_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_err_no) |-> $past(req_i));

  // R8
  gap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_GAP && cnt_q > GAP_W'(1)) |=> sys_err_no);

  // R9
  gap_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_GAP && cnt_q <= GAP_W'(1) && req_i) |=> !sys_err_no);
endmodule

// File: rtl/irq_diag_ctrl.sv
`timescale 1ns/1ps
module irq_diag_ctrl
  import irq_diag_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned N_GP  = 8,
  parameter int unsigned N_FG  = 8,
  parameter int unsigned GAP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        clk_err_i,
  input  logic [1:0]        sys_err_i,
  input  logic [N_GP-1:0]   gp_evt_i,
  input  logic [N_FG-1:0]   fg_evt_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_waddr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  input  logic [ADDR_W-1:0] reg_raddr_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              sys_err_no
);
  localparam int unsigned ERR_W = 4;

  logic [7:0]       diag_q;
  logic [GAP_W-1:0] gap_q;
  logic [ERR_W-1:0] mask_err_q;
  logic [N_GP-1:0]  mask_gp_q;
  logic [N_FG-1:0]  mask_fg_q;

  logic [1:0]       clk_eff, sys_eff;
  logic [N_GP-1:0]  gp_eff;
  logic [N_FG-1:0]  fg_eff;

  logic [ERR_W-1:0] clr_err, stat_err;
  logic [N_GP-1:0]  clr_gp, stat_gp;
  logic [N_FG-1:0]  clr_fg, stat_fg;
  logic             req_err, req_gp, req_fg;

  // control registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      diag_q     <= '0;
      gap_q      <= '0;
      mask_err_q <= '0;
      mask_gp_q  <= '0;
      mask_fg_q  <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_e'(reg_waddr_i))
        REG_DIAG:     diag_q     <= reg_wdata_i[7:0];
        REG_GAP:      gap_q      <= reg_wdata_i[GAP_W-1:0];
        REG_MASK_ERR: mask_err_q <= reg_wdata_i[ERR_W-1:0];
        REG_MASK_GP:  mask_gp_q  <= reg_wdata_i[N_GP-1:0];
        REG_MASK_FG:  mask_fg_q  <= reg_wdata_i[N_FG-1:0];
        default: ;
      endcase
    end
  end

  // write-one-to-clear strobes
  always_comb begin
    clr_err = '0;
    clr_gp  = '0;
    clr_fg  = '0;
    if (reg_we_i) begin
      unique case (reg_addr_e'(reg_waddr_i))
        REG_STAT_ERR: clr_err = reg_wdata_i[ERR_W-1:0];
        REG_STAT_GP:  clr_gp  = reg_wdata_i[N_GP-1:0];
        REG_STAT_FG:  clr_fg  = reg_wdata_i[N_FG-1:0];
        default: ;
      endcase
    end
  end

  irq_ovr_mux #(.N_GP(N_GP), .N_FG(N_FG)) u_ovr (
    .diag_i    (diag_q),
    .clk_err_i (clk_err_i),
    .sys_err_i (sys_err_i),
    .gp_evt_i  (gp_evt_i),
    .fg_evt_i  (fg_evt_i),
    .clk_err_o (clk_eff),
    .sys_err_o (sys_eff),
    .gp_evt_o  (gp_eff),
    .fg_evt_o  (fg_eff)
  );

  irq_tier #(.W(ERR_W)) u_tier_err (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .evt_i ({sys_eff, clk_eff}), .clr_i (clr_err), .mask_i (mask_err_q),
    .status_o (stat_err), .req_o (req_err)
  );

  irq_tier #(.W(N_GP)) u_tier_gp (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .evt_i (gp_eff), .clr_i (clr_gp), .mask_i (mask_gp_q),
    .status_o (stat_gp), .req_o (req_gp)
  );

  irq_tier #(.W(N_FG)) u_tier_fg (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .evt_i (fg_eff), .clr_i (clr_fg), .mask_i (mask_fg_q),
    .status_o (stat_fg), .req_o (req_fg)
  );

  irq_gap_seq #(.GAP_W(GAP_W)) u_gap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_err | req_gp | req_fg),
    .gap_i      (gap_q),
    .sys_err_no (sys_err_no)
  );

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_e'(reg_raddr_i))
      REG_DIAG:     reg_rdata_o[7:0]       = diag_q;
      REG_GAP:      reg_rdata_o[GAP_W-1:0] = gap_q;
      REG_MASK_ERR: reg_rdata_o[ERR_W-1:0] = mask_err_q;
      REG_MASK_GP:  reg_rdata_o[N_GP-1:0]  = mask_gp_q;
      REG_MASK_FG:  reg_rdata_o[N_FG-1:0]  = mask_fg_q;
      REG_STAT_ERR: reg_rdata_o[ERR_W-1:0] = stat_err;
      REG_STAT_GP:  reg_rdata_o[N_GP-1:0]  = stat_gp;
      REG_STAT_FG:  reg_rdata_o[N_FG-1:0]  = stat_fg;
      default: ;
    endcase
  end

  // R5
  ovr_off_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diag_q[7:6] != DIAG_OVR_ON) |->
      ({sys_eff, clk_eff, gp_eff, fg_eff} == {sys_err_i, clk_err_i, gp_evt_i, fg_evt_i}));

  // R7
  ovr_other_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gp_eff[N_GP-1:1] == gp_evt_i[N_GP-1:1]) && (fg_eff[N_FG-1:1] == fg_evt_i[N_FG-1:1]));

  // R6
  ovr_err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (diag_q[7:6] == DIAG_OVR_ON) |-> ({clk_eff, sys_eff} == diag_q[5:2]));
endmodule

// File: tb/irq_diag_ctrl_test.sv
`timescale 1ns/1ps
module irq_diag_ctrl_test;
  localparam int unsigned DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    clk_err = '0;
  logic [1:0]    sys_err = '0;
  logic [7:0]    gp_evt = '0;
  logic [7:0]    fg_evt = '0;
  logic          we = 1'b0;
  logic [2:0]    waddr = '0;
  logic [DW-1:0] wdata = '0;
  logic [2:0]    raddr = '0;
  logic [DW-1:0] rdata;
  logic          err_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_diag_ctrl uut (
    .clk_i (clk), .rst_ni (rst_n),
    .clk_err_i (clk_err), .sys_err_i (sys_err),
    .gp_evt_i (gp_evt), .fg_evt_i (fg_evt),
    .reg_we_i (we), .reg_waddr_i (waddr), .reg_wdata_i (wdata),
    .reg_raddr_i (raddr), .reg_rdata_o (rdata),
    .sys_err_no (err_n)
  );

  typedef struct {
    logic [2:0]    addr;
    logic [DW-1:0] exp;
    string         tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares read data when an expected item is queued
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      rd_item_t it;
      it = sb_q.pop_front();
      n_tests++;
      if (rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s: addr %0d actual 0x%02h expected 0x%02h", it.tag, it.addr, rdata, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1'b1; waddr = a; wdata = d;
    tick(1);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    raddr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk); #1;
    @(posedge clk); #1;
  endtask

  task automatic chk_out(input logic e, input string tag);
    @(negedge clk);
    check(tag, int'(err_n), int'(e));
    @(posedge clk); #1;
  endtask

  // counts consecutive high samples of sys_err_no, starting now
  task automatic measure_high(output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (err_n) n++;
      else if (n > 0) break;
    end
    @(posedge clk); #1;
  endtask

  task automatic clear_all();
    wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(3'd0, 8'h00, "R1 diag");
    rd(3'd1, 8'h00, "R1 gap");
    rd(3'd3, 8'h00, "R1 mask_gp");
    rd(3'd5, 8'h00, "R1 stat_err");
    rd(3'd6, 8'h00, "R1 stat_gp");
    rd(3'd7, 8'h00, "R1 stat_fg");
    chk_out(1'b1, "R1 out");

    // R4 latency, R2 map
    clk_err = 2'b10;
    chk_out(1'b1, "R4 before edge");
    clk_err = 2'b00;
    chk_out(1'b1, "R4 after first edge");
    chk_out(1'b0, "R4 after second edge");
    rd(3'd5, 8'h02, "R2 clk_err1 bit");

    // R3 write-one-to-clear
    wr(3'd5, 8'h01);
    rd(3'd5, 8'h02, "R3 zero leaves bit");
    wr(3'd5, 8'h02);
    rd(3'd5, 8'h00, "R3 one clears bit");
    chk_out(1'b1, "R11 release after clear");

    // R2 sys error map, level held does not relatch
    sys_err = 2'b01; tick(1); sys_err = 2'b00; tick(1);
    rd(3'd5, 8'h04, "R2 sys_err0 bit");
    wr(3'd5, 8'h04);
    gp_evt[3] = 1'b1; tick(2);
    rd(3'd6, 8'h08, "R2 gp3 bit");
    wr(3'd6, 8'h08); tick(2);
    rd(3'd6, 8'h00, "R2 level no relatch");
    gp_evt[3] = 1'b0; tick(1);
    chk_out(1'b1, "R11 idle");

    // R4 mask, R11 masking releases
    wr(3'd3, 8'h20);
    gp_evt[5] = 1'b1; tick(1); gp_evt[5] = 1'b0; tick(3);
    chk_out(1'b1, "R4 masked bit no output");
    rd(3'd6, 8'h20, "R4 masked bit still latched");
    wr(3'd3, 8'h00); tick(2);
    chk_out(1'b0, "R4 unmasked asserts");
    wr(3'd3, 8'h20); tick(1);
    chk_out(1'b1, "R11 mask releases");
    wr(3'd6, 8'h20); wr(3'd3, 8'h00);

    // R5 non-enabling codes
    wr(3'd0, 8'hBF); tick(2);
    rd(3'd5, 8'h00, "R5 code 10 err");
    rd(3'd6, 8'h00, "R5 code 10 gp");
    wr(3'd0, 8'hFF); tick(2);
    rd(3'd5, 8'h00, "R5 code 11 err");
    rd(3'd7, 8'h00, "R5 code 11 fg");
    wr(3'd0, 8'h3F); tick(2);
    rd(3'd5, 8'h00, "R5 code 00 err");

    // R6 R7 override all
    wr(3'd0, 8'h7F); tick(2);
    rd(3'd5, 8'h0F, "R6 all err via diag");
    rd(3'd6, 8'h01, "R7 gp0 via diag");
    rd(3'd7, 8'h01, "R7 fg0 via diag");
    wr(3'd0, 8'h40);
    clear_all();
    wr(3'd0, 8'h60); tick(2);
    rd(3'd5, 8'h02, "R6 bit5 to clk_err1");
    wr(3'd0, 8'h48); tick(2);
    rd(3'd5, 8'h0A, "R6 bit3 to sys_err1");
    wr(3'd0, 8'h42); tick(2);
    rd(3'd6, 8'h01, "R7 bit1 to gp0");
    rd(3'd7, 8'h00, "R7 fg0 untouched");
    rd(3'd0, 8'h42, "R10 diag readback");
    clear_all();

    // R6 R7 pins ignored while overridden
    clk_err = 2'b11; sys_err = 2'b11; gp_evt = 8'h03; fg_evt = 8'h11;
    tick(1);
    clk_err = 2'b00; sys_err = 2'b00; gp_evt = 8'h00; fg_evt = 8'h00;
    tick(1);
    rd(3'd5, 8'h00, "R6 error pins ignored");
    rd(3'd6, 8'h02, "R7 gp0 pin ignored gp1 passes");
    rd(3'd7, 8'h10, "R7 fg0 pin ignored fg4 passes");
    wr(3'd0, 8'h00);
    clear_all(); tick(2);
    chk_out(1'b1, "R11 all clear");

    // R8 R9 gap of 5 with pending interrupt
    wr(3'd1, 8'd5);
    rd(3'd1, 8'd5, "R10 gap readback");
    fg_evt[2] = 1'b1; tick(1); fg_evt[2] = 1'b0; tick(3);
    chk_out(1'b0, "R4 fg2 asserts");
    wr(3'd7, 8'h04);
    fg_evt[3] = 1'b1; tick(1); fg_evt[3] = 1'b0;
    measure_high(n);
    check("R8 R9 gap 5 high cycles", n, 5);
    chk_out(1'b0, "R9 pending asserted after gap");
    wr(3'd7, 8'h08); tick(20);
    chk_out(1'b1, "R8 stays idle with no request");

    // R8 zero gap
    wr(3'd1, 8'd0);
    fg_evt[5] = 1'b1; tick(1); fg_evt[5] = 1'b0; tick(3);
    wr(3'd7, 8'h20);
    fg_evt[6] = 1'b1; tick(1); fg_evt[6] = 1'b0;
    measure_high(n);
    check("R8 gap 0 high cycles", n, 1);
    wr(3'd7, 8'h40); tick(3);

    // R9 late arrival inside gap of 8
    wr(3'd1, 8'd8);
    fg_evt[1] = 1'b1; tick(1); fg_evt[1] = 1'b0; tick(3);
    wr(3'd7, 8'h02); tick(4);
    fg_evt[7] = 1'b1; tick(1); fg_evt[7] = 1'b0;
    measure_high(n);
    check("R9 mid-gap arrival remaining cycles", n, 4);
    rd(3'd7, 8'h80, "R9 status kept during gap");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule